// File: doc/BRIEF.md
# Control and Status Register File with Completion Handshake

This block holds a small set of 64-bit control and status registers that two parties reach in different ways. Software uses one shared, address-based bus. It presents an address together with a one-cycle read strobe or a one-cycle write strobe. The block answers each access with a one-cycle completion pulse, and read data is valid only during that pulse. Hardware does not use the bus. Each field has its own point-to-point port through which logic can observe the field, load it and clear it.

The default map has two kinds of register. Each of `NUM_RW` data registers carries one 32-bit field in bits 31:0 that both sides may read and write and that hardware may clear. Bits 63:32 of a data register are reserved. One counter register follows them. Its field counts up under a hardware enable, and software may only read it. Software handles one access at a time. Any strobe that arrives while a completion is still being signalled is dropped.

Top module: `csr_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, `sw_done` becomes 0 after that edge, and so do `sw_rdata`, every field on `hw_field_q` and `hw_cnt_q`.
- R2: When `sw_read_en` is high in cycle k and no completion is showing in cycle k, `sw_done` is 1 in cycle k+1. In that cycle `sw_rdata` carries the value that the register at `sw_addr` held in cycle k.
- R3: A write that is accepted in cycle k loads `sw_wdata[31:0]` into the data field at `sw_addr`. The new value appears on `hw_field_q` in cycle k+1, and `sw_done` is 1 in that same cycle. Bits 63:32 of `sw_wdata` are ignored, and reserved bits always read as 0.
- R4: `sw_rdata` is 0 in every cycle in which `sw_done` is 0. It is also 0 in the completion cycle of a write. If both strobes are high together, the access is a write.
- R5: A strobe in a cycle in which `sw_done` is 1 is ignored. It produces no completion in the next cycle and changes no field.
- R6: Addresses `0 .. NUM_RW-1` select data registers, and address `NUM_RW` selects the counter. An access to any other address still completes, reads 0 and changes nothing.
- R7: When `hw_clear[i]` is high in cycle k, field i is 0 in cycle k+1. This holds even if a software write or a hardware write to that field arrives in the same cycle.
- R8: When a software write and `hw_wr_en[i]` target field i in the same cycle and no clear is present, the software data wins.
- R9: When `hw_wr_en[i]` is high with no clear and no software write to field i, field i takes slice i of `hw_wr_data` (bits `i*32 +: 32`) in the next cycle. When no request of any kind targets field i, the field holds its value.
- R10: The counter field occupies bits `CNT_W-1:0` of the counter register. It rises by one in each cycle in which `hw_cnt_en` is high and wraps to 0 after its maximum value. Otherwise it holds. A software write to the counter register has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_addr | input | ADDR_W | Register address of the software access |
| sw_read_en | input | 1 | One-cycle read strobe |
| sw_write_en | input | 1 | One-cycle write strobe |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Read data, valid only while sw_done is high |
| sw_done | output | 1 | One-cycle completion pulse |
| hw_wr_en | input | NUM_RW | Per-field hardware load enable |
| hw_wr_data | input | NUM_RW*FIELD_W | Hardware load data, one slice per field |
| hw_clear | input | NUM_RW | Per-field hardware clear |
| hw_field_q | output | NUM_RW*FIELD_W | Current value of every data field |
| hw_cnt_en | input | 1 | Counter increment enable |
| hw_cnt_q | output | CNT_W | Current counter value |

## Verification
The handshake properties assume that software follows the bus rules: one strobe per access, address and data stable in the strobe cycle, and no new access until the completion pulse has gone. The single-pulse and ignored-strobe properties are also written to hold when a strobe lands on the completion cycle. The bench does this on purpose in a directed test, and its random phase offers strobes in any cycle, so the drop behaviour is exercised as well. Hardware clears are kept rare in the random phase so that software and hardware loads stay visible. The counter width is narrowed in the bench so that wrap-around falls within the run.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int REG_W = 64;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sw_op_e;

    typedef struct packed {
        logic             done;
        logic [REG_W-1:0] data;
    } sw_rsp_t;

    function automatic sw_op_e decode_op(input logic rd, input logic wr, input logic busy);
        if (busy)
            return OP_IDLE;
        else if (wr)
            return OP_WRITE;
        else if (rd)
            return OP_READ;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/csr_rw_field.sv
module csr_rw_field #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    input  logic         hw_we,
    input  logic [W-1:0] hw_wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (sw_we)
            q <= sw_wdata;
        else if (hw_we)
            q <= hw_wdata;
    end

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R8
    sw_over_hw_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && sw_we) |=> (q == $past(sw_wdata)));

    // R9
    hw_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !sw_we && hw_we) |=> (q == $past(hw_wdata)));

endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= q + W'(1);
    end

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(q) + W'(1)));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/csr_bus_ctrl.sv
module csr_bus_ctrl
    import csr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NUM_RW = 2,
    localparam int NUM_SLOTS = NUM_RW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [REG_W-1:0]  slot_rdata [NUM_SLOTS],
    output logic [NUM_RW-1:0] wr_hit,
    output logic              done,
    output logic [REG_W-1:0]  rdata
);

    sw_op_e           op;
    sw_rsp_t          rsp_q;
    logic [REG_W-1:0] sel_data;
    logic             mapped;

    assign op = decode_op(rd, wr, rsp_q.done);

    always_comb begin
        sel_data = '0;
        mapped   = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (addr == ADDR_W'(i)) begin
                sel_data = slot_rdata[i];
                mapped   = 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_hit
            assign wr_hit[g] = (op == OP_WRITE) && (addr == ADDR_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.done <= (op != OP_IDLE);
            rsp_q.data <= (op == OP_READ) ? sel_data : '0;
        end
    end

    assign done  = rsp_q.done;
    assign rdata = rsp_q.data;

    // R2
    ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd || wr) && !done) |=> done);

    // R5
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    busy_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_hit == '0));

    // R4
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> (rdata == '0));

    // R6
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (wr_hit == '0));

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit));

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_RW  = 2,
    parameter int FIELD_W = 32,
    parameter int CNT_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         sw_addr,
    input  logic                      sw_read_en,
    input  logic                      sw_write_en,
    input  logic [REG_W-1:0]          sw_wdata,
    output logic [REG_W-1:0]          sw_rdata,
    output logic                      sw_done,
    input  logic [NUM_RW-1:0]         hw_wr_en,
    input  logic [NUM_RW*FIELD_W-1:0] hw_wr_data,
    input  logic [NUM_RW-1:0]         hw_clear,
    output logic [NUM_RW*FIELD_W-1:0] hw_field_q,
    input  logic                      hw_cnt_en,
    output logic [CNT_W-1:0]          hw_cnt_q
);

    localparam int NUM_SLOTS = NUM_RW + 1;
    localparam int PAD_F     = REG_W - FIELD_W;
    localparam int PAD_C     = REG_W - CNT_W;

    logic [REG_W-1:0]  slot_rdata [NUM_SLOTS];
    logic [NUM_RW-1:0] wr_hit;
    logic              unused_hi;

    assign unused_hi = ^sw_wdata[REG_W-1:FIELD_W];

    csr_bus_ctrl #(
        .ADDR_W (ADDR_W),
        .NUM_RW (NUM_RW)
    ) u_bus (
        .clk        (clk),
        .rst        (rst),
        .addr       (sw_addr),
        .rd         (sw_read_en),
        .wr         (sw_write_en),
        .slot_rdata (slot_rdata),
        .wr_hit     (wr_hit),
        .done       (sw_done),
        .rdata      (sw_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_field
            logic [FIELD_W-1:0] q;
            csr_rw_field #(.W(FIELD_W)) u_field (
                .clk      (clk),
                .rst      (rst),
                .clr      (hw_clear[g]),
                .sw_we    (wr_hit[g]),
                .sw_wdata (sw_wdata[FIELD_W-1:0]),
                .hw_we    (hw_wr_en[g]),
                .hw_wdata (hw_wr_data[g*FIELD_W +: FIELD_W]),
                .q        (q)
            );
            assign hw_field_q[g*FIELD_W +: FIELD_W] = q;
            assign slot_rdata[g] = {{PAD_F{1'b0}}, q};
        end
    endgenerate

    csr_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .en  (hw_cnt_en),
        .q   (hw_cnt_q)
    );

    assign slot_rdata[NUM_RW] = {{PAD_C{1'b0}}, hw_cnt_q};

endmodule

// File: tb/csr_regfile_bench.sv
module csr_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 4;
    localparam int NUM_RW  = 2;
    localparam int FIELD_W = 32;
    localparam int CNT_W   = 8;

    logic                      clk = 1'b0;
    logic                      rst;
    logic [ADDR_W-1:0]         sw_addr;
    logic                      sw_read_en;
    logic                      sw_write_en;
    logic [63:0]               sw_wdata;
    logic [63:0]               sw_rdata;
    logic                      sw_done;
    logic [NUM_RW-1:0]         hw_wr_en;
    logic [NUM_RW*FIELD_W-1:0] hw_wr_data;
    logic [NUM_RW-1:0]         hw_clear;
    logic [NUM_RW*FIELD_W-1:0] hw_field_q;
    logic                      hw_cnt_en;
    logic [CNT_W-1:0]          hw_cnt_q;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0]      m_field [NUM_RW];
    logic [CNT_W-1:0] m_cnt;
    logic             m_done;
    logic [63:0]      m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_regfile #(
        .ADDR_W (ADDR_W), .NUM_RW (NUM_RW), .FIELD_W (FIELD_W), .CNT_W (CNT_W)
    ) u_csr_regfile (
        .clk (clk), .rst (rst), .sw_addr (sw_addr), .sw_read_en (sw_read_en),
        .sw_write_en (sw_write_en), .sw_wdata (sw_wdata), .sw_rdata (sw_rdata),
        .sw_done (sw_done), .hw_wr_en (hw_wr_en), .hw_wr_data (hw_wr_data),
        .hw_clear (hw_clear), .hw_field_q (hw_field_q), .hw_cnt_en (hw_cnt_en),
        .hw_cnt_q (hw_cnt_q)
    );

    function automatic logic [63:0] ref_read(input int a);
        if (a < NUM_RW)
            return {32'd0, m_field[a]};
        else if (a == NUM_RW)
            return {{(64-CNT_W){1'b0}}, m_cnt};
        else
            return 64'd0;
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input string tag);
        logic        acc;
        logic [63:0] nrd;
        if (rst) begin
            for (int i = 0; i < NUM_RW; i++) m_field[i] = '0;
            m_cnt = '0; m_done = 1'b0; m_rdata = '0;
        end else begin
            acc = (sw_read_en || sw_write_en) && !m_done;
            nrd = (acc && !sw_write_en) ? ref_read(int'(sw_addr)) : 64'd0;
            for (int i = 0; i < NUM_RW; i++) begin
                if (hw_clear[i])
                    m_field[i] = '0;
                else if (acc && sw_write_en && int'(sw_addr) == i)
                    m_field[i] = sw_wdata[31:0];
                else if (hw_wr_en[i])
                    m_field[i] = hw_wr_data[i*FIELD_W +: FIELD_W];
            end
            if (hw_cnt_en) m_cnt = m_cnt + 1'b1;
            m_done = acc; m_rdata = nrd;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "sw_done", {63'd0, sw_done}, {63'd0, m_done});
        check(tag, "sw_rdata", sw_rdata, m_rdata);
        for (int i = 0; i < NUM_RW; i++)
            check(tag, $sformatf("field%0d", i), {32'd0, hw_field_q[i*FIELD_W +: FIELD_W]}, {32'd0, m_field[i]});
        check(tag, "counter", {{(64-CNT_W){1'b0}}, hw_cnt_q}, {{(64-CNT_W){1'b0}}, m_cnt});
    endtask

    task automatic idle_inputs();
        sw_read_en = 0; sw_write_en = 0; hw_wr_en = '0; hw_clear = '0;
    endtask

    task automatic sw_op(input string tag, input logic wr, input int a, input logic [63:0] d);
        sw_addr = ADDR_W'(a); sw_wdata = d;
        sw_write_en = wr; sw_read_en = !wr;
        step(tag);
        sw_read_en = 0; sw_write_en = 0;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; sw_addr = '0; sw_wdata = '0; hw_wr_data = '0; hw_cnt_en = 0;
        idle_inputs();
        repeat (3) step("R1");
        rst = 0;
        step("R1");

        // R9: hardware loads
        hw_wr_en = 2'b11; hw_wr_data = {32'hB0B0_0002, 32'hA0A0_0001};
        step("R9");
        hw_wr_en = '0; hw_wr_data = '0;
        step("R9");

        // R2: reads of each data register
        sw_op("R2", 0, 0, 64'd0);
        sw_op("R2", 0, 1, 64'd0);

        // R3: writes with upper garbage, read back
        sw_op("R3", 1, 0, 64'hFFFF_FFFF_1234_5678);
        sw_op("R3", 1, 1, 64'hDEAD_BEEF_8765_4321);
        sw_op("R3", 0, 0, 64'd0);
        sw_op("R4", 0, 1, 64'd0);

        // R5: strobe during completion is dropped
        sw_addr = 0; sw_wdata = 64'h0000_0000_1111_1111; sw_write_en = 1;
        step("R5");
        sw_wdata = 64'h0000_0000_2222_2222;
        step("R5");
        sw_write_en = 0;
        step("R5");
        sw_addr = 1; sw_read_en = 1;
        step("R5");
        step("R5");
        sw_read_en = 0;
        step("R5");

        // R6: unmapped addresses
        sw_op("R6", 1, 7, 64'h0000_0000_5555_5555);
        sw_op("R6", 0, 7, 64'd0);
        sw_op("R6", 0, 15, 64'd0);

        // R7: clear beats software and hardware writes
        sw_addr = 0; sw_wdata = 64'h0000_0000_7777_7777; sw_write_en = 1;
        hw_clear = 2'b01; hw_wr_en = 2'b11; hw_wr_data = {32'h9999_9999, 32'h8888_8888};
        step("R7");
        idle_inputs();
        step("R7");

        // R8: software beats hardware
        sw_addr = 1; sw_wdata = 64'h0000_0000_ABCD_0001; sw_write_en = 1;
        hw_wr_en = 2'b10; hw_wr_data = {32'h0BAD_0BAD, 32'd0};
        step("R8");
        idle_inputs();
        step("R8");

        // R10: counter, wrap, read and ignored write
        hw_cnt_en = 1;
        repeat (300) step("R10");
        sw_op("R10", 0, 2, 64'd0);
        sw_op("R10", 1, 2, 64'hFFFF_FFFF_FFFF_FFFF);
        hw_cnt_en = 0;
        sw_op("R10", 0, 2, 64'd0);
        step("R10");

        // mixed random traffic
        for (int n = 0; n < 1500; n++) begin
            sw_addr     = ADDR_W'($urandom_range(0, 4));
            sw_wdata    = {$urandom, $urandom};
            sw_read_en  = ($urandom_range(0, 3) == 0);
            sw_write_en = ($urandom_range(0, 3) == 0);
            hw_wr_en    = NUM_RW'($urandom);
            hw_wr_data  = {$urandom, $urandom};
            hw_clear    = {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
            hw_cnt_en   = $urandom_range(0, 1) == 1;
            step("R2");
        end
        idle_inputs();
        step("R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule